// File: doc/BRIEF.md
# Training-Byte Polarity Corrector

This block sits on a slave node of a half-duplex differential serial link, between the local UART and the line transceiver. After reset it listens for a training byte from the bus controller. It compares that byte with a reference pattern captured at reset and works out whether the two bus conductors are cross-wired. It then inverts or passes serial data in both directions to match.

Until training resolves, the node is receive-only. The transmit output is held at the idle mark level and a transmit-allow status stays low, so the node never drives the bus with an unknown polarity. There are three outcomes for a training byte. A byte equal to the pattern locks the link as straight. A byte equal to the bitwise complement of the pattern locks it as inverted. Any other byte is discarded, and the block keeps waiting. Once locked, the polarity is frozen until the next synchronous reset.

Top module: `polarity_trainer`

## Requirements
- R1: While reset is high and in the cycle after reset is released, trainDone, polarityInv and txAllow are all 0.
- R2: The reference pattern is the value of trainPattern captured on every clock edge where rst is 1. Changes to trainPattern while rst is 0 have no effect on later comparisons.
- R3: When the block is untrained and byteValid is 1 with byteData equal to the pattern, trainDone becomes 1 and polarityInv stays 0 from the next cycle.
- R4: When the block is untrained and byteValid is 1 with byteData equal to the bitwise complement of the pattern, trainDone and polarityInv both become 1 from the next cycle.
- R5: An untrained byte that equals neither the pattern nor its complement leaves trainDone and polarityInv at 0. A later valid training byte is still accepted.
- R6: rxFixed equals rxRaw XOR polarityInv in the same cycle, with no register delay. Before training it equals rxRaw.
- R7: txAllow equals trainDone. While trainDone is 0, txFixed is held at 1 (idle mark). Otherwise txFixed equals txRaw XOR polarityInv in the same cycle.
- R8: Once trainDone is 1, later bytes of any value leave trainDone and polarityInv unchanged until reset.
- R9: A synchronous reset from the trained state returns the block to untrained and non-inverted on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also captures the pattern |
| trainPattern | input | BYTE_W | Reference training pattern, sampled during reset |
| rxRaw | input | 1 | Serial receive bit from the transceiver |
| txRaw | input | 1 | Serial transmit bit from the local UART |
| byteValid | input | 1 | Strobe: byteData holds a newly received byte |
| byteData | input | BYTE_W | Byte received by the local UART |
| rxFixed | output | 1 | Polarity-corrected receive bit to the UART |
| txFixed | output | 1 | Polarity-corrected transmit bit to the transceiver |
| txAllow | output | 1 | High once training is resolved; gates the driver enable |
| polarityInv | output | 1 | 1 when the link was found cross-wired |
| trainDone | output | 1 | 1 once a training byte has been accepted |

## Verification
The status flags are registered, so a decisive training byte shows on trainDone and polarityInv exactly one edge after the cycle in which byteValid was presented. rxFixed, txFixed and txAllow respond in the same cycle as the input or flag they depend on. The bench drives inputs just after a falling edge and compares every output a quarter period later against a behavioural model that it updates on each rising edge. As a result, each flag comparison falls in the first cycle where the new value is due, and each serial-path comparison sees the current inputs.

// File: rtl/polarity_pkg.sv
package polarity_pkg;

  // Strobes issued by the control FSM to the datapath.
  typedef struct packed {
    logic lockStraight;   // accept training, keep data unchanged
    logic lockInverted;   // accept training, invert both directions
  } polCtrl_t;

  typedef enum logic [0:0] {
    ST_WAIT   = 1'b0,
    ST_LOCKED = 1'b1
  } polState_t;

endpackage

// File: rtl/polarity_datapath.sv
module polarity_datapath
  import polarity_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] trainPattern,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              rxRaw,
  input  logic              txRaw,
  input  logic              txGate,
  input  polCtrl_t          ctrlStrobe,
  output logic              matchStraight,
  output logic              matchInverted,
  output logic              invFlag,
  output logic              rxFixed,
  output logic              txFixed
);

  logic [BYTE_W-1:0] patternReg;

  // Reference pattern: reloaded on every reset edge, held otherwise.
  always_ff @(posedge clk) begin
    if (rst) patternReg <= trainPattern;
  end

  assign matchStraight = (byteData == patternReg);
  assign matchInverted = (byteData == ~patternReg);

  // Polarity flag: set only by the inverted-lock strobe, cleared by reset.
  always_ff @(posedge clk) begin
    if (rst)                          invFlag <= 1'b0;
    else if (ctrlStrobe.lockInverted) invFlag <= 1'b1;
    else if (ctrlStrobe.lockStraight) invFlag <= 1'b0;
  end

  // Both directions share the same XOR; transmit parks at idle until gated.
  assign rxFixed = rxRaw ^ invFlag;
  assign txFixed = txGate ? (txRaw ^ invFlag) : IDLE_LEVEL;

  // R1 / R9: reset leaves the flag clear
  assert_reset_clears_R9: assert property (@(posedge clk)
    rst |=> !invFlag);

  // R8: once the gate is open, the flag holds its value
  assert_flag_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (txGate && !ctrlStrobe.lockInverted && !ctrlStrobe.lockStraight) |=> (invFlag == $past(invFlag)));

  // R7: transmit output sits at idle while gated off
  assert_tx_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !txGate |-> (txFixed == IDLE_LEVEL));

endmodule

// File: rtl/polarity_ctrl.sv
module polarity_ctrl
  import polarity_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     byteValid,
  input  logic     matchStraight,
  input  logic     matchInverted,
  input  logic     invFlag,
  output polCtrl_t ctrlStrobe,
  output logic     trainDone
);

  polState_t state, stateNext;

  always_comb begin
    stateNext  = state;
    ctrlStrobe = '0;
    if (state == ST_WAIT && byteValid) begin
      if (matchStraight) begin
        ctrlStrobe.lockStraight = 1'b1;
        stateNext = ST_LOCKED;
      end else if (matchInverted) begin
        ctrlStrobe.lockInverted = 1'b1;
        stateNext = ST_LOCKED;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_WAIT;
    else     state <= stateNext;
  end

  assign trainDone = (state == ST_LOCKED);

  // R3: a matching byte locks straight
  assert_lock_straight_R3: assert property (@(posedge clk) disable iff (rst)
    (!trainDone && byteValid && matchStraight) |=> (trainDone && !invFlag));

  // R4: a complemented byte locks inverted
  assert_lock_inverted_R4: assert property (@(posedge clk) disable iff (rst)
    (!trainDone && byteValid && matchInverted) |=> (trainDone && invFlag));

  // R5: an unrecognised byte keeps the block waiting
  assert_reject_waits_R5: assert property (@(posedge clk) disable iff (rst)
    (!trainDone && (!byteValid || (!matchStraight && !matchInverted))) |=> !trainDone);

  // R8: locked state persists until reset
  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    trainDone |=> trainDone);

  // R1: reset returns to untrained
  assert_reset_untrained_R1: assert property (@(posedge clk)
    rst |=> !trainDone);

endmodule

// File: rtl/polarity_trainer.sv
module polarity_trainer
  import polarity_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] trainPattern,
  input  logic              rxRaw,
  input  logic              txRaw,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  output logic              rxFixed,
  output logic              txFixed,
  output logic              txAllow,
  output logic              polarityInv,
  output logic              trainDone
);

  polCtrl_t ctrlStrobe;
  logic     matchStraight;
  logic     matchInverted;
  logic     invFlag;
  logic     doneFlag;

  polarity_ctrl u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .byteValid     (byteValid),
    .matchStraight (matchStraight),
    .matchInverted (matchInverted),
    .invFlag       (invFlag),
    .ctrlStrobe    (ctrlStrobe),
    .trainDone     (doneFlag)
  );

  polarity_datapath #(
    .BYTE_W     (BYTE_W),
    .IDLE_LEVEL (IDLE_LEVEL)
  ) u_datapath (
    .clk           (clk),
    .rst           (rst),
    .trainPattern  (trainPattern),
    .byteData      (byteData),
    .rxRaw         (rxRaw),
    .txRaw         (txRaw),
    .txGate        (doneFlag),
    .ctrlStrobe    (ctrlStrobe),
    .matchStraight (matchStraight),
    .matchInverted (matchInverted),
    .invFlag       (invFlag),
    .rxFixed       (rxFixed),
    .txFixed       (txFixed)
  );

  assign txAllow     = doneFlag;
  assign polarityInv = invFlag;
  assign trainDone   = doneFlag;

endmodule

// File: tb/polarity_trainer_tb.sv
module polarity_trainer_tb;

  localparam int  BYTE_W   = 8;
  localparam time PERIOD   = 10ns;
  localparam int  WATCHDOG = 5000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [BYTE_W-1:0] trainPattern = '0;
  logic              rxRaw = 1'b0;
  logic              txRaw = 1'b0;
  logic              byteValid = 1'b0;
  logic [BYTE_W-1:0] byteData = '0;
  logic              rxFixed, txFixed, txAllow, polarityInv, trainDone;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // behavioural reference
  bit              mDone = 0;
  bit              mInv  = 0;
  bit [BYTE_W-1:0] mPat  = '0;

  always #(PERIOD/2) clk = ~clk;

  polarity_trainer #(.BYTE_W(BYTE_W)) u_dut (
    .clk(clk), .rst(rst), .trainPattern(trainPattern),
    .rxRaw(rxRaw), .txRaw(txRaw), .byteValid(byteValid), .byteData(byteData),
    .rxFixed(rxFixed), .txFixed(txFixed), .txAllow(txAllow),
    .polarityInv(polarityInv), .trainDone(trainDone)
  );

  always @(posedge clk) begin
    if (rst) begin
      mDone <= 0; mInv <= 0; mPat <= trainPattern;
    end else if (!mDone && byteValid) begin
      if (byteData == mPat) begin
        mDone <= 1;
      end else if (byteData == ~mPat) begin
        mDone <= 1; mInv <= 1;
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll(input string flagTag);
    bit expTx;
    expTx = mDone ? (txRaw ^ mInv) : 1'b1;
    chk({flagTag, " trainDone"},   trainDone,   mDone);
    chk({flagTag, " polarityInv"}, polarityInv, mInv);
    chk("R6 rxFixed",   rxFixed, rxRaw ^ mInv);
    chk("R7 txFixed",   txFixed, expTx);
    chk("R7 txAllow",   txAllow, mDone);
  endtask

  task automatic step(input string tag, input bit r, input bit rx, input bit tx,
                      input bit bv, input bit [BYTE_W-1:0] d);
    @(negedge clk);
    rst = r; rxRaw = rx; txRaw = tx; byteValid = bv; byteData = d;
    #(PERIOD/4);
    compareAll(tag);
  endtask

  // serial traffic with no byte strobe
  task automatic traffic(input string tag, input int n);
    for (int i = 0; i < n; i++)
      step(tag, 0, i[0], i[1], 0, '0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1 / R2: reset with pattern 0xA5
    trainPattern = 8'hA5;
    step("R1", 1, 0, 0, 0, '0);
    step("R1", 1, 1, 1, 0, '0);
    step("R1", 0, 1, 0, 0, '0);
    // R2: change pattern after reset; 0x3C must be rejected
    trainPattern = 8'h3C;
    traffic("R6", 4);
    step("R2", 0, 0, 1, 1, 8'h3C);
    step("R2", 0, 1, 1, 0, '0);
    // R5: neither pattern nor complement
    step("R5", 0, 1, 0, 1, 8'hA4);
    step("R5", 0, 0, 0, 1, 8'h00);
    traffic("R5", 3);
    // R4: complement of 0xA5 is 0x5A -> inverted lock
    step("R4", 0, 1, 1, 1, 8'h5A);
    step("R4", 0, 1, 0, 0, '0);
    traffic("R7", 4);
    // R8: later bytes, including the true pattern, change nothing
    step("R8", 0, 0, 1, 1, 8'hA5);
    step("R8", 0, 1, 0, 1, 8'h5A);
    step("R8", 0, 0, 0, 1, 8'h11);
    traffic("R8", 3);
    // R9: reset from locked state, capture 0xC3
    trainPattern = 8'hC3;
    step("R9", 1, 1, 1, 0, '0);
    step("R9", 0, 0, 1, 0, '0);
    traffic("R9", 2);
    // R3: straight lock on the new pattern, in the same cycle as serial traffic
    step("R3", 0, 1, 0, 1, 8'hC3);
    step("R3", 0, 0, 1, 0, '0);
    traffic("R7", 4);
    step("R8", 0, 1, 1, 1, 8'h3C);
    traffic("R8", 2);
    // R5 then success: reject first, then accept complement
    step("R9", 1, 0, 0, 0, '0);
    step("R5", 0, 0, 0, 1, 8'hFF);
    step("R5", 0, 1, 1, 1, 8'h3C);
    traffic("R4", 3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule